// File: doc/BRIEF.md
# SATA Link Power-State Controller

This block runs the host side of a SATA link through its three power conditions: fully active, the shallow Partial state and the deeper Slumber state. Software starts an entry by writing a request bit. The block then repeats the matching power-management request primitive toward the device until the device answers. An acknowledge moves the link into the requested state. A negative acknowledge leaves the request pending, and the primitive keeps going out.

The device may also ask for a low-power state. The controller answers each such request according to a four-bit enable field. It accepts with an acknowledge and changes state, or it refuses with a negative acknowledge. A low-power state ends in one of two ways. Software can write a wake bit, which makes the block issue one COMWAKE pulse and then wait for the device's out-of-band answer. Any out-of-band activity from the device also ends it. The current state is reported twice, as an encoded four-bit field and as separate flag bits. The link layer is abstracted into primitive strobes carrying a three-bit code.

Top module: `sata_lpm_ctrl`

## Requirements
- R1: A write with `ctl_wdata[0]`=1 while active sets request flag `misc[0]`. From the next cycle, the block outputs `tx_valid`=1 with code PMREQ_P (1) every cycle until the device responds. The primitive codes are PMREQ_P=1, PMREQ_S=2, PMACK=3 and PMNAK=4.
- R2: A write with `ctl_wdata[1]`=1 sets `misc[1]` and repeats PMREQ_S (2) in the same way. If both request bits are pending, PMREQ_P is sent and Partial is the target.
- R3: If PMACK (3) arrives while a request is pending, the targeted state is entered on the next cycle, and both request flags clear. A PMNAK (4) changes nothing: the state stays active, the flag stays set and the request keeps being sent.
- R4: A device PMREQ_P in the active state gets a PMACK on the next cycle, and Partial is entered, only when `ack_en[3:2]`=00 and `ack_en[0]`=1. In every other case the reply is PMNAK and the state stays active.
- R5: A device PMREQ_S in the active state gets a PMACK on the next cycle, and Slumber is entered, only when `ack_en[3:2]`=00 and `ack_en[1]`=1. In every other case the reply is PMNAK and the state stays active.
- R6: `stat_pwr` reads 0000 with no link, 0001 when active, 0010 in Partial and 0110 in Slumber. `misc[4]` flags Partial and `misc[5]` flags Slumber, and at most one of these two flags is set.
- R7: In a low-power state, a write with `ctl_wdata[2]`=1 sets wake flag `misc[2]`. On the next cycle `comwake_tx` pulses for one cycle and the flag clears, while the reported state is held until the device answers. In the active state, a wake write has no effect.
- R8: `oob_rx` in Partial or Slumber returns the block to active on the next cycle. In the active state it has no effect.
- R9: While `link_up` is low, the state reads no-link and all request and wake flags are clear. Writes made then are ignored. The block becomes active one cycle after `link_up` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| link_up | input | 1 | Link established by the physical layer |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control bits: 0 Partial request, 1 Slumber request, 2 wake |
| ack_en | input | 4 | Enable field for device-initiated requests |
| rx_valid | input | 1 | Primitive received strobe |
| rx_code | input | 3 | Received primitive code |
| oob_rx | input | 1 | Out-of-band activity detected from the device |
| tx_valid | output | 1 | Primitive send strobe |
| tx_code | output | 3 | Primitive code to send |
| comwake_tx | output | 1 | One-cycle COMWAKE issue pulse |
| stat_pwr | output | 4 | Encoded power status |
| misc | output | 6 | Flags: 0/1 requests pending, 2 wake pending, 4 Partial, 5 Slumber |

## Verification
Several properties are checked on every cycle. A pending request keeps its primitive going out, an acknowledge enters the target state, and a negative acknowledge leaves the request intact. A device request that is not enabled is refused. The wake flag lives for a single cycle, and out-of-band activity leaves the low-power state. Losing the link clears everything. Some behaviour only the bench scenarios can show. These are the full encode table across all enable patterns, the priority of Partial when both bits are written together, and a wake write in the active state having no effect. They also include the held status while waiting for the device after COMWAKE, and writes being dropped while no link is present.

// File: rtl/sata_lpm_ctrl.sv
module sata_lpm_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       ctl_wr,
  input  logic [2:0] ctl_wdata,
  input  logic [3:0] ack_en,
  input  logic       rx_valid,
  input  logic [2:0] rx_code,
  input  logic       oob_rx,
  output logic       tx_valid,
  output logic [2:0] tx_code,
  output logic       comwake_tx,
  output logic [3:0] stat_pwr,
  output logic [5:0] misc
);
  localparam logic [2:0] P_REQP = 3'd1, P_REQS = 3'd2, P_ACK = 3'd3, P_NAK = 3'd4;

  typedef enum logic [1:0] {S_NOLINK, S_ACTIVE, S_PARTIAL, S_SLUMBER} st_t;

  st_t  st;
  logic req_p, req_s, wake, waking;

  wire ok_p    = (ack_en[3:2] == 2'b00) && ack_en[0];
  wire ok_s    = (ack_en[3:2] == 2'b00) && ack_en[1];
  wire rx_reqp = rx_valid && rx_code == P_REQP;
  wire rx_reqs = rx_valid && rx_code == P_REQS;
  wire rx_ack  = rx_valid && rx_code == P_ACK;
  wire pend    = req_p | req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_NOLINK;
      req_p <= 1'b0; req_s <= 1'b0; wake <= 1'b0; waking <= 1'b0;
      tx_valid <= 1'b0; tx_code <= 3'd0; comwake_tx <= 1'b0;
    end else begin
      tx_valid   <= 1'b0;
      tx_code    <= 3'd0;
      comwake_tx <= 1'b0;
      if (!link_up) begin
        st <= S_NOLINK;
        req_p <= 1'b0; req_s <= 1'b0; wake <= 1'b0; waking <= 1'b0;
      end else begin
        case (st)
          S_NOLINK: st <= S_ACTIVE;
          S_ACTIVE: begin
            if (ctl_wr) begin
              req_p <= req_p | ctl_wdata[0];
              req_s <= req_s | ctl_wdata[1];
            end
            if (rx_reqp) begin
              tx_valid <= 1'b1;
              tx_code  <= ok_p ? P_ACK : P_NAK;
              if (ok_p) begin st <= S_PARTIAL; req_p <= 1'b0; req_s <= 1'b0; end
            end else if (rx_reqs) begin
              tx_valid <= 1'b1;
              tx_code  <= ok_s ? P_ACK : P_NAK;
              if (ok_s) begin st <= S_SLUMBER; req_p <= 1'b0; req_s <= 1'b0; end
            end else if (pend && rx_ack) begin
              st    <= req_p ? S_PARTIAL : S_SLUMBER;
              req_p <= 1'b0;
              req_s <= 1'b0;
            end else if (pend) begin
              tx_valid <= 1'b1;
              tx_code  <= req_p ? P_REQP : P_REQS;
            end
          end
          default: begin
            if (oob_rx) begin
              st <= S_ACTIVE; wake <= 1'b0; waking <= 1'b0;
            end else if (wake) begin
              comwake_tx <= 1'b1; wake <= 1'b0; waking <= 1'b1;
            end else if (ctl_wr && ctl_wdata[2] && !waking) begin
              wake <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_ACTIVE:  stat_pwr = 4'b0001;
      S_PARTIAL: stat_pwr = 4'b0010;
      S_SLUMBER: stat_pwr = 4'b0110;
      default:   stat_pwr = 4'b0000;
    endcase
  end

  assign misc = {st == S_SLUMBER, st == S_PARTIAL, 1'b0, wake, req_s, req_p};
endmodule

// File: rtl/sata_lpm_ctrl_chk.sv
module sata_lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_up,
  input logic       ctl_wr,
  input logic [2:0] ctl_wdata,
  input logic [3:0] ack_en,
  input logic       rx_valid,
  input logic [2:0] rx_code,
  input logic       oob_rx,
  input logic       tx_valid,
  input logic [2:0] tx_code,
  input logic       comwake_tx,
  input logic [3:0] stat_pwr,
  input logic [5:0] misc
);
  wire act = stat_pwr == 4'b0001 && link_up;

  a_r1_req_p_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    act && misc[0] && !rx_valid |=> tx_valid && tx_code == 3'd1);

  a_r2_req_s_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    act && misc[1:0] == 2'b10 && !rx_valid |=> tx_valid && tx_code == 3'd2);

  a_r3_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
    act && misc[0] && rx_valid && rx_code == 3'd3 |=> stat_pwr == 4'b0010 && misc[1:0] == 2'b00);

  a_r3_nak_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    act && misc[0] && rx_valid && rx_code == 3'd4 |=> stat_pwr == 4'b0001 && misc[0]);

  a_r4_refuse_p: assert property (@(posedge clk) disable iff (!rst_n)
    act && rx_valid && rx_code == 3'd1 && !(ack_en[3:2] == 2'b00 && ack_en[0])
    |=> tx_valid && tx_code == 3'd4 && stat_pwr == 4'b0001);

  a_r5_refuse_s: assert property (@(posedge clk) disable iff (!rst_n)
    act && rx_valid && rx_code == 3'd2 && !(ack_en[3:2] == 2'b00 && ack_en[1])
    |=> tx_valid && tx_code == 3'd4 && stat_pwr == 4'b0001);

  a_r6_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(misc[5:4]));

  a_r7_wake_once: assert property (@(posedge clk) disable iff (!rst_n)
    misc[2] |=> !misc[2]);

  a_r7_comwake: assert property (@(posedge clk) disable iff (!rst_n)
    misc[2] && link_up && !oob_rx |=> comwake_tx);

  a_r8_oob_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pwr == 4'b0010 || stat_pwr == 4'b0110) && oob_rx && link_up |=> stat_pwr == 4'b0001);

  a_r9_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> stat_pwr == 4'b0000 && misc == 6'd0);
endmodule

bind sata_lpm_ctrl sata_lpm_ctrl_chk u_chk (.*);

// File: tb/sata_lpm_ctrl_bench.sv
module sata_lpm_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, link_up = 1'b0, ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = 3'd0;
  logic [3:0] ack_en = 4'd0;
  logic rx_valid = 1'b0, oob_rx = 1'b0;
  logic [2:0] rx_code = 3'd0;
  logic tx_valid, comwake_tx;
  logic [2:0] tx_code;
  logic [3:0] stat_pwr;
  logic [5:0] misc;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  sata_lpm_ctrl u_sata_lpm_ctrl (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(logic [2:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; cyc(); ctl_wr = 1'b0; ctl_wdata = 3'd0;
  endtask

  task automatic rx(logic [2:0] c);
    rx_valid = 1'b1; rx_code = c; cyc(); rx_valid = 1'b0; rx_code = 3'd0;
  endtask

  task automatic oob();
    oob_rx = 1'b1; cyc(); oob_rx = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset stat", stat_pwr, 4'b0000);
    check("R9 reset misc", misc, 6'd0);
    wr(3'b011);
    check("R9 write without link ignored", misc, 6'd0);
    link_up = 1'b1; cyc();
    check("R6 active code", stat_pwr, 4'b0001);
    check("R9 no leftover request", misc, 6'd0);
  endtask

  task automatic t_host_partial();
    wr(3'b001);
    check("R1 request flag", misc, 6'b000001);
    for (int i = 0; i < 3; i++) begin
      cyc();
      check("R1 PMREQ_P repeats", {tx_valid, tx_code}, {1'b1, 3'd1});
    end
    rx(3'd4);
    check("R3 NAK stays active", stat_pwr, 4'b0001);
    check("R3 NAK keeps request", misc, 6'b000001);
    cyc();
    check("R3 request resent after NAK", {tx_valid, tx_code}, {1'b1, 3'd1});
    rx(3'd3);
    check("R3 ACK enters Partial", stat_pwr, 4'b0010);
    check("R6 Partial flag", misc, 6'b010000);
    check("R3 sending stops", tx_valid, 1'b0);
    oob();
    check("R8 OOB ends Partial", stat_pwr, 4'b0001);
    oob();
    check("R8 OOB in active ignored", stat_pwr, 4'b0001);
  endtask

  task automatic t_host_slumber();
    wr(3'b011);
    cyc();
    check("R2 both set: Partial first", {tx_valid, tx_code}, {1'b1, 3'd1});
    rx(3'd3);
    check("R2 priority target Partial", stat_pwr, 4'b0010);
    check("R3 both flags cleared", misc, 6'b010000);
    oob();
    wr(3'b010);
    cyc();
    check("R2 PMREQ_S sent", {tx_valid, tx_code}, {1'b1, 3'd2});
    rx(3'd3);
    check("R6 Slumber code", stat_pwr, 4'b0110);
    check("R6 Slumber flag", misc, 6'b100000);
  endtask

  task automatic t_wake();
    wr(3'b100);
    check("R7 wake flag set", misc, 6'b100100);
    check("R7 no COMWAKE yet", comwake_tx, 1'b0);
    cyc();
    check("R7 COMWAKE pulse", comwake_tx, 1'b1);
    check("R7 wake self-clears", misc, 6'b100000);
    cyc();
    check("R7 pulse one cycle", comwake_tx, 1'b0);
    check("R7 state held", stat_pwr, 4'b0110);
    oob();
    check("R7 active after device OOB", stat_pwr, 4'b0001);
    wr(3'b100);
    check("R7 wake in active ignored", misc, 6'd0);
    cyc();
    check("R7 no COMWAKE in active", comwake_tx, 1'b0);
  endtask

  task automatic dev_req(string tag, logic [2:0] c, logic [3:0] en, logic [2:0] rep, logic [3:0] st);
    ack_en = en;
    rx(c);
    check({tag, " reply"}, {tx_valid, tx_code}, {1'b1, rep});
    check({tag, " state"}, stat_pwr, st);
    if (st != 4'b0001) oob();
  endtask

  task automatic t_device();
    dev_req("R4 en=0001", 3'd1, 4'b0001, 3'd3, 4'b0010);
    dev_req("R4 en=0011", 3'd1, 4'b0011, 3'd3, 4'b0010);
    dev_req("R4 en=0101", 3'd1, 4'b0101, 3'd4, 4'b0001);
    dev_req("R4 en=0010", 3'd1, 4'b0010, 3'd4, 4'b0001);
    dev_req("R5 en=0010", 3'd2, 4'b0010, 3'd3, 4'b0110);
    dev_req("R5 en=0011", 3'd2, 4'b0011, 3'd3, 4'b0110);
    dev_req("R5 en=0001", 3'd2, 4'b0001, 3'd4, 4'b0001);
    dev_req("R5 en=1010", 3'd2, 4'b1010, 3'd4, 4'b0001);
  endtask

  task automatic t_link_drop();
    wr(3'b001);
    link_up = 1'b0; cyc();
    check("R9 drop stat", stat_pwr, 4'b0000);
    check("R9 drop clears request", misc, 6'd0);
    link_up = 1'b1; cyc(); cyc();
    check("R9 relink no request sent", tx_valid, 1'b0);
    check("R9 relink active", stat_pwr, 4'b0001);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_host_partial();
    t_host_slumber();
    t_wake();
    t_device();
    t_link_drop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule